// File: doc/BRIEF.md
# Fuse bank controller with protection

This block is a register-mapped controller for a small one-time-programmable fuse array. The array has two banks. Each bank has 32 rows of 8 fuse bits, held in flops that only a program operation can set. Every row has a cache copy. The cache loads from the fuses after each hard reset, and software can read it or override it over a simple 32-bit register bus.

Software programs one fuse bit at a time, or runs an explicit sense that reads one physical row into a data register. Row 0 of each bank is that bank's protection word. Its fuse bits block cache reads, cache overrides, programming and sensing of the bank, and every violation sets its own sticky error bit.

A power-on reset input clears the fuse image. A hard reset leaves the fuses alone and reloads the caches. Status bits and error bits each have a mask, and together they drive a single interrupt line.

Top module: `efuse_ctrl`

## Requirements
- R1: After hard reset, the status register (0x00), the error register (0x08) and sense data (0x1C) read 0, the divide register (0x3C) reads its reset parameter, and irq is low.
- R2: One cycle after hard reset ends, every cache word reads the fuse value of its row. Power-on reset clears all fuses to 0, and a hard reset alone leaves the fuses unchanged.
- R3: A write to a cache word (bank 0 at 0x800 + 4*row, bank 1 at 0xC00 + 4*row, data in bits 7:0) replaces that cache row until the next hard reset. The fuse row, seen through a sense, is unchanged.
- R4: Writing control (0x10) with bits 0 and 5 set, while the key register (0x28) holds 0xAA, programs a fuse bit. The bank is upper address (0x14) bit 3, the row is lower address (0x18) bits 7:3, and the bit is lower address bits 2:0. On completion the fuse bit and the matching cache bit are 1 and status bit 1 is set.
- R5: A program with a wrong key, or on a bank whose protection fuse bit 7 (write protect) is set, starts no operation, leaves the fuse unchanged, sets no done flag and sets error bit 6.
- R6: A fuse bit that is 1 stays 1 until power-on reset.
- R7: Error bits 6:1 are sticky. Writing 1 to a bit of the error register clears it, and writing 0 leaves it set.
- R8: Writing control bit 3 senses the addressed row. On completion the fuse row appears in sense data bits 7:0 and status bit 0 is set. If the bank's protection bit 3 is set, nothing runs and error bit 2 is set.
- R9: Status bit 7 (busy) stays high for divide+1 cycles after the starting write.
- R10: While busy, writes to control, upper address, lower address, key or divide are ignored and set error bit 3.
- R11: If the bank's protection bit 5 is set, a cache read returns 0 and sets error bit 4.
- R12: If the bank's protection bit 6 is set, a cache write is ignored and sets error bit 5.
- R13: irq is high when any status bit ANDed with the status mask (0x04) or any error bit ANDed with the error mask (0x0C) is 1.
- R14: Any write to the status register clears both done flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous active low; reloads the caches |
| por_n | input | 1 | Power-on reset, asynchronous active low; clears the fuses |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Masked status or error interrupt |

## Verification
The bench builds the block with a 4-bit divide register that resets to 2. Every program and sense therefore completes in three busy cycles. At that length the bench can count the busy window exactly, and it can land a locked-register write inside the window on the cycle after the start. The default 32-row, 8-bit geometry is kept so that the address split and the cache word offsets are exercised as specified. Protection is set by programming row 0 of bank 1 one bit at a time, which shows each protection bit acting alone.

// File: rtl/efuse_pkg.sv
`timescale 1ns/1ps
package efuse_pkg;
  localparam logic [11:0] A_STAT  = 12'h000;
  localparam logic [11:0] A_SMASK = 12'h004;
  localparam logic [11:0] A_ERR   = 12'h008;
  localparam logic [11:0] A_EMASK = 12'h00C;
  localparam logic [11:0] A_CTRL  = 12'h010;
  localparam logic [11:0] A_UPPER = 12'h014;
  localparam logic [11:0] A_LOWER = 12'h018;
  localparam logic [11:0] A_SDATA = 12'h01C;
  localparam logic [11:0] A_KEY   = 12'h028;
  localparam logic [11:0] A_DIV   = 12'h03C;

  localparam int unsigned CTL_PROG  = 0;
  localparam int unsigned CTL_SENSE = 3;
  localparam int unsigned CTL_PULSE = 5;

  localparam int unsigned ST_BUSY  = 7;

  localparam int unsigned E_WPROT  = 6;
  localparam int unsigned E_OPROT  = 5;
  localparam int unsigned E_RPROT  = 4;
  localparam int unsigned E_LOCKED = 3;
  localparam int unsigned E_SENSE  = 2;
  // bits 6:1 exist; the parity bit (1) is never raised here
  localparam logic [7:0]  ERR_IMPL = 8'h7E;

  localparam int unsigned P_WRITE = 7;
  localparam int unsigned P_OVR   = 6;
  localparam int unsigned P_READ  = 5;
  localparam int unsigned P_SENSE = 3;

  typedef enum logic {OP_PROG = 1'b0, OP_SENSE = 1'b1} op_e;
endpackage

// File: rtl/efuse_rst_sync.sv
`timescale 1ns/1ps
module efuse_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/efuse_store.sv
`timescale 1ns/1ps
module efuse_store #(
  parameter int unsigned NBANK = 2,
  parameter int unsigned ROWS  = 32,
  parameter int unsigned ROW_W = 8,
  localparam int unsigned BKW  = $clog2(NBANK),
  localparam int unsigned RW   = $clog2(ROWS),
  localparam int unsigned BW   = $clog2(ROW_W),
  localparam int unsigned FW   = NBANK * ROWS * ROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             prog_en,
  input  logic [BKW-1:0]   prog_bank,
  input  logic [RW-1:0]    prog_row,
  input  logic [BW-1:0]    prog_bit,
  input  logic             ovr_en,
  input  logic [BKW-1:0]   ovr_bank,
  input  logic [RW-1:0]    ovr_row,
  input  logic [ROW_W-1:0] ovr_data,
  output logic [FW-1:0]    fuse_img,
  output logic [FW-1:0]    cache_img
);
  logic load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b1;
    else        load_q <= 1'b0;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int unsigned BASE = (b * ROWS + r) * ROW_W;
      logic [ROW_W-1:0] fuse_q, fuse_d, cache_q, cache_d;
      logic hit_p, hit_o, cache_en;

      always_comb begin
        hit_p = prog_en && (prog_bank == BKW'(b)) && (prog_row == RW'(r));
        hit_o = ovr_en && (ovr_bank == BKW'(b)) && (ovr_row == RW'(r));
        fuse_d = fuse_q;
        if (hit_p) fuse_d[prog_bit] = 1'b1;
        cache_d = cache_q;
        if (load_q) cache_d = fuse_q;
        else begin
          if (hit_o) cache_d = ovr_data;
          if (hit_p) cache_d[prog_bit] = 1'b1;
        end
        cache_en = load_q || hit_o || hit_p;
      end

      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)     fuse_q <= '0;
        else if (hit_p) fuse_q <= fuse_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cache_q <= '0;
        else if (cache_en) cache_q <= cache_d;
      end

      assign fuse_img[BASE +: ROW_W]  = fuse_q;
      assign cache_img[BASE +: ROW_W] = cache_q;
    end
  end
endmodule

// File: rtl/efuse_seq.sv
`timescale 1ns/1ps
module efuse_seq #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  output logic             busy,
  output logic             done
);
  logic             busy_q, busy_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done   = 1'b0;
    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done   = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = div;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/efuse_ctrl.sv
`timescale 1ns/1ps
module efuse_ctrl
  import efuse_pkg::*;
#(
  parameter int unsigned ROWS     = 32,
  parameter int unsigned ROW_W    = 8,
  parameter int unsigned DIV_W    = 8,
  parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(15),
  parameter logic [7:0]  PROG_KEY = 8'hAA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int unsigned NBANK = 2;
  localparam int unsigned BKW   = $clog2(NBANK);
  localparam int unsigned RW    = $clog2(ROWS);
  localparam int unsigned BW    = $clog2(ROW_W);
  localparam int unsigned FW    = NBANK * ROWS * ROW_W;

  logic rst_s, por_s;
  efuse_rst_sync u_rs_por (.clk(clk), .arst_n(por_n), .srst_n(por_s));
  efuse_rst_sync u_rs_sys (.clk(clk), .arst_n(rst_n & por_n), .srst_n(rst_s));

  logic [FW-1:0] fuse_img, cache_img;
  logic busy, done, start, ovr_en, prog_en;
  logic wr_acc, rd_acc, cache_hit, lock_reg, stat_clr;
  logic [BKW-1:0] c_bank, t_bank;
  logic [RW-1:0]  c_row, t_row;
  logic [BW-1:0]  t_bit;
  logic [ROW_W-1:0] prot [NBANK];
  logic [ROW_W-1:0] c_prot, t_prot, t_fuse, c_cache;

  logic [7:0] smask_q, smask_d, emask_q, emask_d, ua_q, ua_d, la_q, la_d;
  logic [7:0] key_q, key_d, err_q, err_d, err_set, err_clr, stat_vec;
  logic [ROW_W-1:0] sdat_q, sdat_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic pdone_q, pdone_d, sdone_q, sdone_d;
  op_e  op_q, op_d;
  logic unused_wdata;

  assign wr_acc    = bus_sel & bus_wr;
  assign rd_acc    = bus_sel & ~bus_wr;
  assign cache_hit = bus_addr[11] && (bus_addr[9:7] == 3'b000);
  assign c_bank    = bus_addr[10];
  assign c_row     = bus_addr[2 +: RW];
  assign t_bank    = ua_q[3];
  assign t_row     = RW'(la_q[7:3]);
  assign t_bit     = BW'(la_q[2:0]);
  assign unused_wdata = ^bus_wdata[31:8];

  for (genvar b = 0; b < NBANK; b++) begin : g_prot
    assign prot[b] = fuse_img[b * ROWS * ROW_W +: ROW_W];
  end

  assign c_prot  = prot[c_bank];
  assign t_prot  = prot[t_bank];
  assign t_fuse  = fuse_img[(int'(t_bank) * ROWS + int'(t_row)) * ROW_W +: ROW_W];
  assign c_cache = cache_img[(int'(c_bank) * ROWS + int'(c_row)) * ROW_W +: ROW_W];

  efuse_seq #(.DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_s), .start(start), .div(div_q), .busy(busy), .done(done)
  );

  assign prog_en = done && (op_q == OP_PROG);

  efuse_store #(.NBANK(NBANK), .ROWS(ROWS), .ROW_W(ROW_W)) u_store (
    .clk(clk), .rst_n(rst_s), .por_n(por_s),
    .prog_en(prog_en), .prog_bank(t_bank), .prog_row(t_row), .prog_bit(t_bit),
    .ovr_en(ovr_en), .ovr_bank(c_bank), .ovr_row(c_row), .ovr_data(bus_wdata[ROW_W-1:0]),
    .fuse_img(fuse_img), .cache_img(cache_img)
  );

  always_comb begin
    smask_d = smask_q; emask_d = emask_q; ua_d = ua_q; la_d = la_q;
    key_d = key_q; div_d = div_q; op_d = op_q;
    err_set = '0; start = 1'b0; ovr_en = 1'b0;
    lock_reg = (bus_addr == A_CTRL) || (bus_addr == A_UPPER) || (bus_addr == A_LOWER) ||
               (bus_addr == A_KEY) || (bus_addr == A_DIV);
    if (wr_acc && busy && lock_reg) begin
      err_set[E_LOCKED] = 1'b1;
    end else if (wr_acc) begin
      case (bus_addr)
        A_SMASK: smask_d = bus_wdata[7:0];
        A_EMASK: emask_d = bus_wdata[7:0];
        A_UPPER: ua_d    = bus_wdata[7:0];
        A_LOWER: la_d    = bus_wdata[7:0];
        A_KEY:   key_d   = bus_wdata[7:0];
        A_DIV:   div_d   = bus_wdata[DIV_W-1:0];
        A_CTRL: begin
          if (bus_wdata[CTL_PROG] && bus_wdata[CTL_PULSE]) begin
            if ((key_q == PROG_KEY) && !t_prot[P_WRITE]) begin
              start = 1'b1; op_d = OP_PROG;
            end else err_set[E_WPROT] = 1'b1;
          end else if (bus_wdata[CTL_SENSE]) begin
            if (!t_prot[P_SENSE]) begin
              start = 1'b1; op_d = OP_SENSE;
            end else err_set[E_SENSE] = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (wr_acc && cache_hit) begin
      if (c_prot[P_OVR]) err_set[E_OPROT] = 1'b1;
      else               ovr_en = 1'b1;
    end
    if (rd_acc && cache_hit && c_prot[P_READ]) err_set[E_RPROT] = 1'b1;
    err_clr  = (wr_acc && bus_addr == A_ERR) ? bus_wdata[7:0] : 8'h00;
    err_d    = ((err_q & ~err_clr) | err_set) & ERR_IMPL;
    stat_clr = wr_acc && (bus_addr == A_STAT);
    pdone_d  = (pdone_q & ~stat_clr) | (done && op_q == OP_PROG);
    sdone_d  = (sdone_q & ~stat_clr) | (done && op_q == OP_SENSE);
    sdat_d   = (done && op_q == OP_SENSE) ? t_fuse : sdat_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      smask_q <= '0; emask_q <= '0; ua_q <= '0; la_q <= '0; key_q <= '0;
      div_q <= DIV_RST; op_q <= OP_PROG; err_q <= '0; sdat_q <= '0;
      pdone_q <= 1'b0; sdone_q <= 1'b0;
    end else begin
      smask_q <= smask_d; emask_q <= emask_d; ua_q <= ua_d; la_q <= la_d;
      key_q <= key_d; div_q <= div_d; err_q <= err_d;
      pdone_q <= pdone_d; sdone_q <= sdone_d;
      if (start) op_q   <= op_d;
      if (done)  sdat_q <= sdat_d;
    end
  end

  assign stat_vec = {busy, 5'b00000, pdone_q, sdone_q};
  assign irq = (|(stat_vec & smask_q)) | (|(err_q & emask_q));

  always_comb begin
    bus_rdata = '0;
    if (cache_hit) begin
      if (!c_prot[P_READ]) bus_rdata[ROW_W-1:0] = c_cache;
    end else begin
      case (bus_addr)
        A_STAT:  bus_rdata[7:0] = stat_vec;
        A_SMASK: bus_rdata[7:0] = smask_q;
        A_ERR:   bus_rdata[7:0] = err_q;
        A_EMASK: bus_rdata[7:0] = emask_q;
        A_UPPER: bus_rdata[7:0] = ua_q;
        A_LOWER: bus_rdata[7:0] = la_q;
        A_SDATA: bus_rdata[ROW_W-1:0] = sdat_q;
        A_KEY:   bus_rdata[7:0] = key_q;
        A_DIV:   bus_rdata[DIV_W-1:0] = div_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/efuse_ctrl_chk.sv
`timescale 1ns/1ps
module efuse_ctrl_chk
  import efuse_pkg::*;
#(
  parameter int unsigned FW = 512
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [11:0]   bus_addr,
  input logic          busy,
  input logic          pdone,
  input logic          sdone,
  input logic [7:0]    err_q,
  input logic [FW-1:0] fuse_img
);
  // R6: a set fuse bit never returns to 0
  p_fuse_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(fuse_img) & ~fuse_img) == '0));

  // R4: fuses change only at the end of a running operation
  p_fuse_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_img != $past(fuse_img)) |-> $past(busy));

  // R10: a key write while busy raises the locked-register error
  p_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_sel && bus_wr && bus_addr == A_KEY) |=> err_q[E_LOCKED]);

  // R9: the end of busy is marked by a done flag
  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (pdone || sdone));

  // R7: error bits drop only after a write to the error register
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(err_q) & ~err_q)) |-> $past(bus_sel && bus_wr && bus_addr == A_ERR));
endmodule

bind efuse_ctrl efuse_ctrl_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_s), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .busy(busy), .pdone(pdone_q), .sdone(sdone_q), .err_q(err_q), .fuse_img(fuse_img)
);

// File: tb/efuse_ctrl_test.sv
`timescale 1ns/1ps
module efuse_ctrl_test;
  import efuse_pkg::*;
  localparam int unsigned DW = 4;
  localparam logic [DW-1:0] DRST = 4'd2;

  logic clk = 1'b0;
  logic rst_n, por_n, bus_sel, bus_wr, irq;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int checks = 0;
  int errors = 0;

  typedef struct { logic [11:0] addr; logic [31:0] exp; string req; } sb_item_t;
  sb_item_t sb_q[$];
  logic mon_en = 1'b0;

  always #5 clk = ~clk;

  efuse_ctrl #(.ROWS(32), .ROW_W(8), .DIV_W(DW), .DIV_RST(DRST), .PROG_KEY(8'hAA)) uut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a read is on the bus
  always begin
    @(negedge clk);
    #2;
    if (mon_en && sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      chk(it.req, bus_rdata, it.exp);
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_exp(logic [11:0] a, logic [31:0] e, string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    sb_q.push_back('{a, e, req});
    mon_en = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; mon_en = 1'b0;
  endtask

  task automatic run_busy(output int n);
    n = 0;
    forever begin
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_STAT;
      #1;
      if (bus_rdata[ST_BUSY]) begin n++; @(negedge clk); end
      else break;
    end
    bus_sel = 1'b0;
  endtask

  task automatic op(int bank, int row, int bitn, logic [31:0] ctl, output int n);
    wr(A_UPPER, 32'(bank << 3));
    wr(A_LOWER, 32'((row << 3) | bitn));
    wr(A_CTRL, ctl);
    run_busy(n);
  endtask

  task automatic hard_reset(logic with_por);
    @(negedge clk);
    rst_n = 1'b0; if (with_por) por_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 0; por_n = 0;
    hard_reset(1'b1);

    // R1 reset state
    rd_exp(A_STAT, 32'h0, "R1");
    rd_exp(A_ERR, 32'h0, "R1");
    rd_exp(A_SDATA, 32'h0, "R1");
    rd_exp(A_DIV, 32'(DRST), "R1");
    chk("R1 irq", 32'(irq), 32'h0);
    rd_exp(12'h814, 32'h0, "R2 por clears");

    // R4 program bank1 row7 bit2, R9 busy length
    wr(A_KEY, 32'hAA);
    op(1, 7, 2, 32'h21, n);
    chk("R9 busy cycles", 32'(n), 32'(DRST) + 1);
    rd_exp(A_STAT, 32'h02, "R4");
    rd_exp(12'hC1C, 32'h04, "R4");
    // R8 sense
    op(1, 7, 0, 32'h08, n);
    chk("R9 sense busy", 32'(n), 32'(DRST) + 1);
    rd_exp(A_STAT, 32'h03, "R8");
    rd_exp(A_SDATA, 32'h04, "R8");
    // R13 status mask
    wr(A_SMASK, 32'h02);
    @(negedge clk); #1; chk("R13 status irq", 32'(irq), 32'h1);
    wr(A_STAT, 32'h0);
    rd_exp(A_STAT, 32'h0, "R14");
    @(negedge clk); #1; chk("R13 irq clears", 32'(irq), 32'h0);
    wr(A_SMASK, 32'h0);

    // R10 locked write during busy
    wr(A_UPPER, 32'h8);
    wr(A_LOWER, 32'h3B);
    wr(A_CTRL, 32'h21);
    wr(A_KEY, 32'h0);
    run_busy(n);
    rd_exp(A_ERR, 32'h08, "R10");
    rd_exp(A_KEY, 32'hAA, "R10");
    rd_exp(12'hC1C, 32'h0C, "R4");
    wr(A_ERR, 32'h08);
    rd_exp(A_ERR, 32'h0, "R7");
    wr(A_STAT, 32'h0);

    // R5 wrong key
    wr(A_KEY, 32'h55);
    op(0, 3, 1, 32'h21, n);
    chk("R5 no busy", 32'(n), 32'h0);
    rd_exp(A_STAT, 32'h0, "R5");
    rd_exp(A_ERR, 32'h40, "R5");
    wr(A_ERR, 32'h0);
    rd_exp(A_ERR, 32'h40, "R7");
    wr(A_EMASK, 32'h40);
    @(negedge clk); #1; chk("R13 error irq", 32'(irq), 32'h1);
    wr(A_EMASK, 32'h0);
    @(negedge clk); #1; chk("R13 masked", 32'(irq), 32'h0);
    wr(A_ERR, 32'h40);
    rd_exp(A_ERR, 32'h0, "R7");
    op(0, 3, 0, 32'h08, n);
    rd_exp(A_SDATA, 32'h0, "R5 fuse unchanged");
    wr(A_STAT, 32'h0);

    // R3 override
    wr(12'h80C, 32'h5A);
    rd_exp(12'h80C, 32'h5A, "R3");
    op(0, 3, 0, 32'h08, n);
    rd_exp(A_SDATA, 32'h0, "R3 fuse kept");

    // R2 and R6 across hard reset
    hard_reset(1'b0);
    rd_exp(12'h80C, 32'h0, "R3 override dropped");
    rd_exp(12'hC1C, 32'h0C, "R2");
    rd_exp(A_STAT, 32'h0, "R1");
    rd_exp(A_DIV, 32'(DRST), "R1");

    // R12 override protect
    wr(A_KEY, 32'hAA);
    op(1, 0, 6, 32'h21, n);
    wr(A_STAT, 32'h0);
    wr(12'hC1C, 32'hFF);
    rd_exp(12'hC1C, 32'h0C, "R12");
    rd_exp(A_ERR, 32'h20, "R12");
    wr(A_ERR, 32'h20);
    // R11 read protect
    op(1, 0, 5, 32'h21, n);
    rd_exp(12'hC1C, 32'h0, "R11");
    rd_exp(A_ERR, 32'h10, "R11");
    wr(A_ERR, 32'h10);
    // R8 sense protect
    op(1, 0, 3, 32'h21, n);
    wr(A_STAT, 32'h0);
    op(1, 7, 0, 32'h08, n);
    chk("R8 no busy", 32'(n), 32'h0);
    rd_exp(A_ERR, 32'h04, "R8");
    rd_exp(A_STAT, 32'h0, "R8");
    rd_exp(A_SDATA, 32'h0, "R8");
    wr(A_ERR, 32'h04);
    // R5 write protect
    op(1, 0, 7, 32'h21, n);
    chk("R9 prog busy", 32'(n), 32'(DRST) + 1);
    wr(A_STAT, 32'h0);
    op(1, 7, 0, 32'h21, n);
    chk("R5 no busy", 32'(n), 32'h0);
    rd_exp(A_ERR, 32'h40, "R5");
    rd_exp(A_STAT, 32'h0, "R5");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule